// File: doc/BRIEF.md
# Serial Flash Command Trigger Arbiter

This block sits between the register write port of a serial flash controller and its command sequencer. When software writes the command register, the arbiter either starts the command or rejects it. It starts a command with a one-cycle launch pulse that carries the latched opcode. It rejects a command when the bus-side read path is active, when the bus grant is held, or when an earlier software command is still running. Each reason for rejection raises its own sticky flag, and the rejected command is dropped with no further effect.

An accepted command is also checked against the continuous-mode state of each attached device. In single-device mode, a command that does not use continuous mode is refused while any device still holds its continuous-mode bit. In parallel mode, every device bit must equal the command's expected mode. A failed check raises the mode error flag and sends nothing to the sequencer. One cycle later the finished flag is still raised, so software always sees the command complete. An interrupt combines all flags through a per-flag enable mask.

Top module: `sf_trig_arbiter`

## Requirements
- R1: A command write (`cmd_wr`) while `bus_rd_active` is high sets flag bit 0 (access conflict) after the next clock edge. No launch follows.
- R2: A command write while `bus_grant` is high and `bus_rd_active` is low sets flag bit 1 (grant conflict). No launch follows.
- R3: While `busy` is high, a write to the command, address or buffer-control register sets flag bit 2 (busy conflict). A command write that is rejected this way does not launch.
- R4: When several rejection conditions apply to one command write, only the highest one is flagged. Access conflict ranks above grant conflict, and grant conflict ranks above busy conflict.
- R5: In single-device mode (`par_mode`=0), take a command that passes arbitration, has `cmd_cont`=0, and arrives while any `dev_cont` bit is 1. It sets flag bit 3 (mode error) and does not launch. Flag bit 4 (finished) is set one cycle after bit 3.
- R6: In parallel mode (`par_mode`=1), a command that passes arbitration counts as a mode error if any `dev_cont` bit differs from `cmd_cont`. The outcome is the same as in R5.
- R7: A command that passes arbitration and the mode check gives `launch`=1 for exactly one cycle, after the write edge. `launch_cmd` then holds the written opcode, and `busy` rises in the same cycle.
- R8: `seq_done` while `busy` is high clears `busy` and sets flag bit 4 (finished) at the same edge. `seq_done` while idle has no effect.
- R9: Flags are sticky. Writing `flag_clr_wr` with a 1 in `flag_clr_data` clears the matching bit. If a clear and a set hit the same bit in the same cycle, the set wins.
- R10: `irq` is 1 exactly when some flag bit is 1 and the matching bit of the enable mask is also 1. The mask is loaded by `irq_en_wr` with `irq_en_data`.
- R11: After reset, `launch`, `busy`, `flags`, `irq` and the enable mask are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe of the command register |
| cmd_data | input | CMD_W | Opcode being written |
| cmd_cont | input | 1 | Continuous mode the written command expects |
| addr_wr | input | 1 | Write strobe of the address register |
| bufctl_wr | input | 1 | Write strobe of the buffer-control register |
| bus_rd_active | input | 1 | Bus-side read access in progress |
| bus_grant | input | 1 | Bus side holds the grant |
| par_mode | input | 1 | 1 = parallel multi-device mode |
| dev_cont | input | NDEV | Continuous-mode bit of each device |
| seq_done | input | 1 | Sequencer has completed the running command |
| flag_clr_wr | input | 1 | Write strobe of the flag-clear register |
| flag_clr_data | input | 5 | Write-1-to-clear mask |
| irq_en_wr | input | 1 | Write strobe of the interrupt enable mask |
| irq_en_data | input | 5 | New enable mask |
| launch | output | 1 | One-cycle start pulse to the sequencer |
| launch_cmd | output | CMD_W | Latched opcode of the launched command |
| busy | output | 1 | A software command is running |
| flags | output | 5 | Sticky flags: 0 access, 1 grant, 2 busy, 3 mode, 4 finished |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same edge. A flag clear can coincide with a new set of the same bit, and `seq_done` can arrive in the same cycle as another command write. The random phase makes clear strobes and done pulses frequent, so both coincidences occur often. A directed step also clears bit 0 while a conflicting write sets it. The bench judges each edge against a model built from the requirements. That model expects the set to win over the clear, and it expects a write that arrives with `seq_done` to still count as a busy conflict, because `busy` only falls at that edge.

// File: rtl/sf_trig_pkg.sv
package sf_trig_pkg;

    localparam int FLAG_W  = 5;
    localparam int FL_ACC  = 0;
    localparam int FL_GNT  = 1;
    localparam int FL_BSY  = 2;
    localparam int FL_MODE = 3;
    localparam int FL_FIN  = 4;

    typedef struct packed {
        logic set_acc;
        logic set_gnt;
        logic set_bsy;
        logic start;
    } trig_dec_t;

endpackage

// File: rtl/sf_trig_decide.sv
module sf_trig_decide
    import sf_trig_pkg::*;
(
    input  logic      cmd_wr,
    input  logic      addr_wr,
    input  logic      bufctl_wr,
    input  logic      bus_rd_active,
    input  logic      bus_grant,
    input  logic      busy,
    output trig_dec_t dec
);

    logic cmd_past_bus;

    always_comb begin
        dec          = '0;
        cmd_past_bus = cmd_wr && !bus_rd_active && !bus_grant;
        dec.set_acc  = cmd_wr && bus_rd_active;
        dec.set_gnt  = cmd_wr && !bus_rd_active && bus_grant;
        dec.set_bsy  = busy && (addr_wr || bufctl_wr || cmd_past_bus);
        dec.start    = cmd_past_bus && !busy;
    end

endmodule

// File: rtl/sf_mode_check.sv
module sf_mode_check #(
    parameter int NDEV = 2
) (
    input  logic            par_mode,
    input  logic [NDEV-1:0] dev_cont,
    input  logic            cmd_cont,
    output logic            mode_err
);

    logic [NDEV-1:0] mism;

    genvar g;
    generate
        for (g = 0; g < NDEV; g++) begin : g_dev
            assign mism[g] = dev_cont[g] ^ cmd_cont;
        end
    endgenerate

    logic collision;
    logic par_error;

    always_comb begin
        collision = !par_mode && !cmd_cont && (|dev_cont);
        par_error = par_mode && (|mism);
        mode_err  = collision || par_error;
    end

endmodule

// File: rtl/sf_flag_bank.sv
module sf_flag_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    input  logic         en_wr,
    input  logic [W-1:0] en_data,
    output logic [W-1:0] flags,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] flg;
        logic [W-1:0] en;
    } bank_t;

    bank_t st_d, st_q;
    logic [W-1:0] clr_mask;
    logic [W-1:0] flg_next;

    assign clr_mask = clr_wr ? clr_data : '0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_flag
            assign flg_next[g] = set_vec[g] | (st_q.flg[g] & ~clr_mask[g]);
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.flg = flg_next;
        if (en_wr) begin
            st_d.en = en_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flg;
    assign irq   = |(st_q.flg & st_q.en);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags)); // R10

endmodule

// File: rtl/sf_trig_arbiter.sv
module sf_trig_arbiter
    import sf_trig_pkg::*;
#(
    parameter int CMD_W = 8,
    parameter int NDEV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              cmd_cont,
    input  logic              addr_wr,
    input  logic              bufctl_wr,
    input  logic              bus_rd_active,
    input  logic              bus_grant,
    input  logic              par_mode,
    input  logic [NDEV-1:0]   dev_cont,
    input  logic              seq_done,
    input  logic              flag_clr_wr,
    input  logic [FLAG_W-1:0] flag_clr_data,
    input  logic              irq_en_wr,
    input  logic [FLAG_W-1:0] irq_en_data,
    output logic              launch,
    output logic [CMD_W-1:0]  launch_cmd,
    output logic              busy,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);

    typedef struct packed {
        logic             busy;
        logic             launch;
        logic [CMD_W-1:0] cmd;
        logic             fin_pend;
    } ctl_t;

    ctl_t        st_d, st_q;
    trig_dec_t   dec;
    logic        mode_err;
    logic [FLAG_W-1:0] set_vec;

    sf_trig_decide u_decide (
        .cmd_wr        (cmd_wr),
        .addr_wr       (addr_wr),
        .bufctl_wr     (bufctl_wr),
        .bus_rd_active (bus_rd_active),
        .bus_grant     (bus_grant),
        .busy          (st_q.busy),
        .dec           (dec)
    );

    sf_mode_check #(.NDEV(NDEV)) u_mode (
        .par_mode (par_mode),
        .dev_cont (dev_cont),
        .cmd_cont (cmd_cont),
        .mode_err (mode_err)
    );

    always_comb begin
        st_d          = st_q;
        st_d.launch   = 1'b0;
        st_d.fin_pend = 1'b0;
        set_vec       = '0;
        set_vec[FL_ACC] = dec.set_acc;
        set_vec[FL_GNT] = dec.set_gnt;
        set_vec[FL_BSY] = dec.set_bsy;
        if (dec.start) begin
            if (mode_err) begin
                set_vec[FL_MODE] = 1'b1;
                st_d.fin_pend    = 1'b1;
            end else begin
                st_d.launch = 1'b1;
                st_d.busy   = 1'b1;
                st_d.cmd    = cmd_data;
            end
        end
        if (st_q.busy && seq_done) begin
            st_d.busy       = 1'b0;
            set_vec[FL_FIN] = 1'b1;
        end
        if (st_q.fin_pend) begin
            set_vec[FL_FIN] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sf_flag_bank #(.W(FLAG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (flag_clr_wr),
        .clr_data (flag_clr_data),
        .en_wr    (irq_en_wr),
        .en_data  (irq_en_data),
        .flags    (flags),
        .irq      (irq)
    );

    assign launch     = st_q.launch;
    assign launch_cmd = st_q.cmd;
    assign busy       = st_q.busy;

    AST_ACC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_rd_active) |=> (!launch && flags[FL_ACC])); // R1

    AST_GNT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !bus_rd_active && bus_grant) |=> (!launch && flags[FL_GNT])); // R2

    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (addr_wr || bufctl_wr)) |=> flags[FL_BSY]); // R3

    AST_ONLY_TOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_rd_active && !addr_wr && !bufctl_wr
         && !flags[FL_GNT] && !flags[FL_BSY]) |=> (!flags[FL_GNT] && !flags[FL_BSY])); // R4

    AST_MODE_THEN_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_MODE]) |=> flags[FL_FIN]); // R5

    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch); // R7

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> busy); // R7

    AST_DONE_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_done) |=> (!busy && flags[FL_FIN])); // R8

endmodule

// File: tb/sf_trig_arbiter_tb.sv
module sf_trig_arbiter_tb;

    localparam int CMD_W = 8;
    localparam int NDEV  = 2;
    localparam int FW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              cmd_wr = 0, cmd_cont = 0, addr_wr = 0, bufctl_wr = 0;
    logic [CMD_W-1:0]  cmd_data = '0;
    logic              bus_rd_active = 0, bus_grant = 0, par_mode = 0, seq_done = 0;
    logic [NDEV-1:0]   dev_cont = '0;
    logic              flag_clr_wr = 0, irq_en_wr = 0;
    logic [FW-1:0]     flag_clr_data = '0, irq_en_data = '0;
    logic              launch, busy, irq;
    logic [CMD_W-1:0]  launch_cmd;
    logic [FW-1:0]     flags;

    sf_trig_arbiter #(.CMD_W(CMD_W), .NDEV(NDEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .cmd_cont(cmd_cont), .addr_wr(addr_wr), .bufctl_wr(bufctl_wr),
        .bus_rd_active(bus_rd_active), .bus_grant(bus_grant), .par_mode(par_mode),
        .dev_cont(dev_cont), .seq_done(seq_done), .flag_clr_wr(flag_clr_wr),
        .flag_clr_data(flag_clr_data), .irq_en_wr(irq_en_wr), .irq_en_data(irq_en_data),
        .launch(launch), .launch_cmd(launch_cmd), .busy(busy), .flags(flags), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    // model state
    logic [FW-1:0]    m_flags = '0, m_en = '0;
    logic             m_busy = 0, m_pend = 0, m_launch = 0;
    logic [CMD_W-1:0] m_cmd = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mode_bad(input logic pm, input logic [NDEV-1:0] dc, input logic cc);
        if (pm) return (dc != {NDEV{cc}});   // R6
        return (!cc && (dc != '0));           // R5
    endfunction

    task automatic idle_inputs();
        cmd_wr = 0; addr_wr = 0; bufctl_wr = 0; seq_done = 0;
        flag_clr_wr = 0; irq_en_wr = 0; bus_rd_active = 0; bus_grant = 0;
    endtask

    // one clock: inputs already driven at negedge; model, edge, compare
    task automatic step();
        logic [FW-1:0] set;
        logic [FW-1:0] clr;
        logic tried, merr;
        set = '0;
        set[0] = cmd_wr && bus_rd_active;
        set[1] = cmd_wr && !bus_rd_active && bus_grant;
        set[2] = m_busy && (addr_wr || bufctl_wr || (cmd_wr && !bus_rd_active && !bus_grant));
        tried  = cmd_wr && !bus_rd_active && !bus_grant && !m_busy;
        merr   = mode_bad(par_mode, dev_cont, cmd_cont);
        set[3] = tried && merr;
        set[4] = m_pend || (m_busy && seq_done);
        clr    = flag_clr_wr ? flag_clr_data : '0;
        m_flags  = (m_flags & ~clr) | set;
        if (irq_en_wr) m_en = irq_en_data;
        m_launch = tried && !merr;
        if (m_launch) m_cmd = cmd_data;
        if (m_busy && seq_done) m_busy = 0;
        if (m_launch) m_busy = 1;
        m_pend = tried && merr;
        @(posedge clk);
        @(negedge clk);
        chk(flags[0] == m_flags[0], "R1 access flag", flags[0], m_flags[0]);
        chk(flags[1] == m_flags[1], "R2 grant flag", flags[1], m_flags[1]);
        chk(flags[2] == m_flags[2], "R3 busy flag", flags[2], m_flags[2]);
        chk(flags[3] == m_flags[3], "R5 mode flag", flags[3], m_flags[3]);
        chk(flags[4] == m_flags[4], "R8 finished flag", flags[4], m_flags[4]);
        chk(launch == m_launch, "R7 launch", launch, m_launch);
        if (m_launch) chk(launch_cmd == m_cmd, "R7 launch_cmd", launch_cmd, m_cmd);
        chk(busy == m_busy, "R8 busy", busy, m_busy);
        chk(irq == |(m_flags & m_en), "R10 irq", irq, |(m_flags & m_en));
    endtask

    task automatic clear_all();
        idle_inputs();
        flag_clr_wr = 1; flag_clr_data = '1;
        step();
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({launch, busy, flags, irq} == '0, "R11 reset outputs", {launch, busy, flags, irq}, 0);
        rst_n = 1;
        @(negedge clk);
        irq_en_wr = 1; irq_en_data = '1;
        step();
        idle_inputs();

        // R7 accepted launch
        cmd_wr = 1; cmd_data = 8'hA5; cmd_cont = 1; par_mode = 0; dev_cont = '0;
        step();
        idle_inputs();
        chk(launch_cmd == 8'hA5, "R7 opcode", launch_cmd, 8'hA5);
        // R4: all three conditions while busy -> only access flag
        cmd_wr = 1; bus_rd_active = 1; bus_grant = 1;
        step();
        idle_inputs();
        chk(flags[2:0] == 3'b001, "R4 priority", flags[2:0], 3'b001);
        // R3 write to address while busy, then done in same cycle as cmd write
        clear_all();
        addr_wr = 1; step(); idle_inputs();
        chk(flags[2], "R3 addr while busy", flags[2], 1);
        cmd_wr = 1; seq_done = 1; step(); idle_inputs();
        chk(!busy && !launch && flags[4], "R8 done with cmd write", {busy, launch, flags[4]}, 3'b001);
        // R6 parallel mismatch
        clear_all();
        par_mode = 1; dev_cont = 2'b01; cmd_cont = 1; cmd_wr = 1;
        step(); idle_inputs();
        chk(flags[3] && !flags[4] && !launch, "R6 parallel mismatch", flags, 5'b01000);
        step();
        chk(flags[4], "R6 finished follows", flags[4], 1);
        // R5 single collision
        clear_all();
        par_mode = 0; dev_cont = 2'b10; cmd_cont = 0; cmd_wr = 1;
        step(); idle_inputs();
        chk(flags[3] && !launch, "R5 collision", flags[3], 1);
        // R9 clear and set same cycle
        clear_all();
        cmd_wr = 1; bus_rd_active = 1; flag_clr_wr = 1; flag_clr_data = 5'b00001;
        step(); idle_inputs();
        chk(flags[0], "R9 set beats clear", flags[0], 1);
        // R8 idle done ignored
        clear_all();
        seq_done = 1; step(); idle_inputs();
        chk(flags == '0 && !busy, "R8 idle done ignored", flags, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            cmd_wr        = ($urandom % 100) < 30;
            cmd_data      = CMD_W'($urandom);
            cmd_cont      = $urandom % 2;
            addr_wr       = ($urandom % 100) < 10;
            bufctl_wr     = ($urandom % 100) < 10;
            bus_rd_active = ($urandom % 100) < 20;
            bus_grant     = ($urandom % 100) < 15;
            par_mode      = $urandom % 2;
            dev_cont      = NDEV'($urandom);
            seq_done      = ($urandom % 100) < 30;
            flag_clr_wr   = ($urandom % 100) < 15;
            flag_clr_data = FW'($urandom);
            irq_en_wr     = ($urandom % 100) < 10;
            irq_en_data   = FW'($urandom);
            step();
        end
        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule